// File: doc/BRIEF.md
# CAN Controller Status Word and Interrupt Source

This block keeps the eight-bit status word of a CAN controller and turns selected changes of that word into a single pending interrupt. The protocol engine feeds it with one-cycle pulses: a frame was transmitted, a frame was received, or an error was detected together with a three-bit error code. It also feeds three error-state levels (error-passive, error-warning and bus-off). Those levels are derived from error counters that live elsewhere.

A CPU port reads the status word and writes its software-writable fields. Three enables come from the controller's control register. The error-interrupt enable and the status-interrupt enable select which events may set the pending flag. A global enable gates that flag onto the interrupt output. A status read acknowledges the pending interrupt. A CPU write can load the unused error code 7 as a marker, so that software can later see whether the engine has reported anything since.

Top module: `can_stat_irq`

## Requirements
- R1: After reset the read data is all zero and `irq` is low. The status read data carries the error code in bits 2:0, transmit-ok in bit 3, receive-ok in bit 4, error-passive in bit 5, error-warning in bit 6 and bus-off in bit 7. Bits 31:8 always read as zero.
- R2: A CPU write loads bits 4:0 of the write data into the error code, transmit-ok and receive-ok fields. Bits 7:5 of the write data have no effect.
- R3: An error pulse loads its code into bits 2:0 on the next clock edge. The codes are 1 stuff, 2 form, 3 acknowledge, 4 recessive-bit, 5 dominant-bit and 6 CRC, with 0 meaning none. A transmit-done or receive-done pulse without an error pulse in the same cycle clears the code to 0. If both pulses arrive in one cycle, the error pulse wins.
- R4: Code 7, once written by the CPU, reads back unchanged until the next engine pulse replaces it.
- R5: Bits 7:5 follow the bus-off, warning and passive input levels with one cycle of delay.
- R6: A rise of bus-off or of error-warning sets the pending interrupt, but only while the error-interrupt enable is high.
- R7: A transmit-done, receive-done or error pulse sets the pending interrupt, but only while the status-interrupt enable is high.
- R8: A change of the error-passive level never sets the pending interrupt. No event sets it while its enable is low.
- R9: CPU writes never set the pending interrupt.
- R10: A status read clears the pending interrupt. If a new source arrives in the same cycle as the read, the interrupt stays pending.
- R11: When an engine pulse and a CPU write hit the same field in one cycle, the engine value is stored.
- R12: `irq` equals the pending flag ANDed with the global enable. Pending holds until a read clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eng_tx_done | input | 1 | Frame transmitted without error (pulse) |
| eng_rx_done | input | 1 | Frame received without error (pulse) |
| eng_err_hit | input | 1 | Bus error detected (pulse) |
| eng_err_code | input | 3 | Code of the detected error |
| eng_passive | input | 1 | Error-passive level |
| eng_warn | input | 1 | Error-warning level |
| eng_bus_off | input | 1 | Bus-off level |
| cpu_rd | input | 1 | Status read strobe |
| cpu_wr | input | 1 | Status write strobe |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Status read data |
| en_err_int | input | 1 | Error-interrupt enable |
| en_stat_int | input | 1 | Status-interrupt enable |
| en_glob_int | input | 1 | Global interrupt enable |
| irq | output | 1 | Interrupt output |

## Verification
The bench goes after collisions. These include a read and a new source in the same edge, an engine pulse and a CPU write on the same field, and an error pulse together with a done pulse. A design that got any of them wrong would lose an interrupt, keep stale software data, or clear a fresh error code. It checks that an error-passive toggle and CPU writes stay silent on `irq`; a design that treated every status change alike would interrupt spuriously. It also sweeps every error code under each enable setting and all 256 write values. A long pseudo-random run is then compared against an arithmetic model, which catches any wrong priority between sources.

// File: rtl/can_stat_pkg.sv
package can_stat_pkg;
  localparam int STAT_W = 8;
  localparam int CODE_W = 3;
  localparam logic [CODE_W-1:0] CODE_NONE = 3'd0;
  localparam logic [CODE_W-1:0] CODE_MARK = 3'd7;

  typedef struct packed {
    logic              bus_off;
    logic              warn;
    logic              passive;
    logic              rx_ok;
    logic              tx_ok;
    logic [CODE_W-1:0] code;
  } stat_t;

  function automatic logic rose(input logic now_lvl, input logic was_lvl);
    return now_lvl & ~was_lvl;
  endfunction

  function automatic logic [CODE_W-1:0] code_next(
      input logic              err_hit,
      input logic [CODE_W-1:0] err_code,
      input logic              frame_ok,
      input logic              wr,
      input logic [CODE_W-1:0] wr_code,
      input logic [CODE_W-1:0] cur);
    if (err_hit)       return err_code;
    else if (frame_ok) return CODE_NONE;
    else if (wr)       return wr_code;
    else               return cur;
  endfunction

  function automatic logic flag_next(input logic hw_set, input logic wr,
                                     input logic wr_val, input logic cur);
    if (hw_set)  return 1'b1;
    else if (wr) return wr_val;
    else         return cur;
  endfunction
endpackage

// File: rtl/can_stat_fields.sv
module can_stat_fields
  import can_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_done,
  input  logic              rx_done,
  input  logic              err_hit,
  input  logic [CODE_W-1:0] err_code,
  input  logic              lvl_passive,
  input  logic              lvl_warn,
  input  logic              lvl_bus_off,
  input  logic              wr,
  input  logic [STAT_W-1:0] wr_data,
  output stat_t             stat,
  output logic              ev_err,
  output logic              ev_stat
);
  stat_t stat_d;
  logic  frame_ok;

  assign frame_ok = tx_done | rx_done;
  assign ev_err   = rose(lvl_bus_off, stat.bus_off) | rose(lvl_warn, stat.warn);
  assign ev_stat  = tx_done | rx_done | err_hit;

  always_comb begin
    stat_d.bus_off = lvl_bus_off;
    stat_d.warn    = lvl_warn;
    stat_d.passive = lvl_passive;
    stat_d.rx_ok   = flag_next(rx_done, wr, wr_data[4], stat.rx_ok);
    stat_d.tx_ok   = flag_next(tx_done, wr, wr_data[3], stat.tx_ok);
    stat_d.code    = code_next(err_hit, err_code, frame_ok, wr,
                               wr_data[CODE_W-1:0], stat.code);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stat <= '0;
    else        stat <= stat_d;
  end

  assert_levels_track_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (stat.bus_off == $past(lvl_bus_off)) && (stat.warn == $past(lvl_warn))
             && (stat.passive == $past(lvl_passive)));
  assert_ok_clears_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ok && !err_hit) |=> stat.code == CODE_NONE);
  assert_err_loads_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    err_hit |=> stat.code == $past(err_code));
  assert_hw_beats_cpu_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && wr) |=> stat.tx_ok);
endmodule

// File: rtl/can_stat_pend.sv
module can_stat_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic src_err,
  input  logic src_stat,
  input  logic rd_clr,
  input  logic glob_en,
  output logic pend,
  output logic irq
);
  logic any_src;
  assign any_src = src_err | src_stat;

  always_ff @(posedge clk) begin
    if (!rst_n)       pend <= 1'b0;
    else if (any_src) pend <= 1'b1;
    else if (rd_clr)  pend <= 1'b0;
  end

  assign irq = pend & glob_en;

  assert_src_sets_pend_R10: assert property (@(posedge clk) disable iff (!rst_n)
    any_src |=> pend);
  assert_read_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !any_src) |=> !pend);
  assert_pend_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !rd_clr) |=> pend);
endmodule

// File: rtl/can_stat_irq.sv
module can_stat_irq
  import can_stat_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eng_tx_done,
  input  logic              eng_rx_done,
  input  logic              eng_err_hit,
  input  logic [CODE_W-1:0] eng_err_code,
  input  logic              eng_passive,
  input  logic              eng_warn,
  input  logic              eng_bus_off,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              en_err_int,
  input  logic              en_stat_int,
  input  logic              en_glob_int,
  output logic              irq
);
  localparam int PAD_W = DATA_W - STAT_W;

  stat_t stat;
  logic  ev_err, ev_stat, src_err, src_stat, pend;

  can_stat_fields u_fields (
    .clk(clk), .rst_n(rst_n),
    .tx_done(eng_tx_done), .rx_done(eng_rx_done),
    .err_hit(eng_err_hit), .err_code(eng_err_code),
    .lvl_passive(eng_passive), .lvl_warn(eng_warn), .lvl_bus_off(eng_bus_off),
    .wr(cpu_wr), .wr_data(cpu_wdata[STAT_W-1:0]),
    .stat(stat), .ev_err(ev_err), .ev_stat(ev_stat)
  );

  assign src_err  = ev_err & en_err_int;
  assign src_stat = ev_stat & en_stat_int;

  can_stat_pend u_pend (
    .clk(clk), .rst_n(rst_n),
    .src_err(src_err), .src_stat(src_stat),
    .rd_clr(cpu_rd), .glob_en(en_glob_int),
    .pend(pend), .irq(irq)
  );

  assign cpu_rdata = {{PAD_W{1'b0}}, stat};

  assert_cpu_wr_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !src_err && !src_stat && !pend) |=> !pend);
  assert_quiet_no_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!eng_tx_done && !eng_rx_done && !eng_err_hit && !ev_err && !pend) |=> !pend);
  assert_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rdata[DATA_W-1:STAT_W] == '0);
endmodule

// File: tb/can_stat_irq_tb.sv
module can_stat_irq_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic tx = 0, rx = 0, eh = 0, ep = 0, ew = 0, bo = 0, rd = 0, wr = 0;
  logic [2:0] code = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic ei = 0, si = 0, gi = 0, irq;

  int n_chk = 0, n_bad = 0;
  logic [7:0] m_stat = 0;
  logic m_pend = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_stat_irq u_dut (
    .clk(clk), .rst_n(rst_n),
    .eng_tx_done(tx), .eng_rx_done(rx), .eng_err_hit(eh), .eng_err_code(code),
    .eng_passive(ep), .eng_warn(ew), .eng_bus_off(bo),
    .cpu_rd(rd), .cpu_wr(wr), .cpu_wdata(wdata), .cpu_rdata(rdata),
    .en_err_int(ei), .en_stat_int(si), .en_glob_int(gi), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one clock: apply inputs at negedge, advance model, compare at next negedge
  task automatic cyc(input logic t, input logic r, input logic e, input logic [2:0] c,
                     input logic p, input logic w, input logic b,
                     input logic rr, input logic ww, input logic [7:0] wd);
    logic [7:0] ns;
    logic src;
    tx = t; rx = r; eh = e; code = c; ep = p; ew = w; bo = b;
    rd = rr; wr = ww; wdata = {24'hA5A5A5, wd};
    src = (ei && ((b && !m_stat[7]) || (w && !m_stat[6]))) || (si && (t || r || e));
    ns[7] = b; ns[6] = w; ns[5] = p;
    ns[4] = r ? 1'b1 : (ww ? wd[4] : m_stat[4]);
    ns[3] = t ? 1'b1 : (ww ? wd[3] : m_stat[3]);
    ns[2:0] = e ? c : ((t || r) ? 3'd0 : (ww ? wd[2:0] : m_stat[2:0]));
    m_pend = src ? 1'b1 : (rr ? 1'b0 : m_pend);
    m_stat = ns;
    @(posedge clk); @(negedge clk);
    tx = 0; rx = 0; eh = 0; rd = 0; wr = 0;
  endtask

  task automatic idle(); cyc(0,0,0,0, ep,ew,bo, 0,0,8'h00); endtask
  task automatic rdclr(); cyc(0,0,0,0, ep,ew,bo, 1,0,8'h00); endtask

  initial begin
    #(CLK_PERIOD*150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    @(negedge clk); @(negedge clk);
    chk("R1 reset rdata", rdata, 32'h0);
    chk("R1 reset irq", {31'b0, irq}, 32'h0);
    rst_n = 1;
    gi = 1;

    // R2: all write values, enables on; writes must not interrupt (R9)
    ei = 1; si = 1;
    for (int v = 0; v < 256; v++) begin
      cyc(0,0,0,0, 0,0,0, 0,1,v[7:0]);
      chk("R2 write readback", rdata, {24'h0, 3'b000, v[4:0]});
      chk("R9 write no irq", {31'b0, irq}, 32'h0);
    end

    // R4: marker code 7 survives idle cycles, replaced by engine
    cyc(0,0,0,0, 0,0,0, 0,1,8'h07);
    for (int k = 0; k < 4; k++) idle();
    chk("R4 marker held", rdata, 32'h7);
    cyc(0,1,0,0, 0,0,0, 0,0,8'h00);
    chk("R4 marker replaced by rx ok", rdata, 32'h10);
    chk("R7 rx raises irq", {31'b0, irq}, 32'h1);
    rdclr();
    chk("R10 read clears", {31'b0, irq}, 32'h0);

    // R3 / R7 / R8: every engine code under each status enable setting
    for (int en = 0; en < 2; en++) begin
      si = en[0]; ei = 0;
      for (int c = 1; c < 7; c++) begin
        cyc(0,0,1,c[2:0], 0,0,0, 0,0,8'h00);
        chk("R3 code loaded", {29'b0, rdata[2:0]}, c);
        chk("R7 R8 err pulse irq", {31'b0, irq}, {31'b0, en[0]});
        cyc(1,0,0,0, 0,0,0, 0,0,8'h00);
        chk("R3 tx ok clears code", {29'b0, rdata[2:0]}, 32'h0);
        rdclr();
      end
    end
    si = 1;
    cyc(1,0,1,3'd5, 0,0,0, 0,0,8'h00);
    chk("R3 error beats done", {29'b0, rdata[2:0]}, 32'h5);
    rdclr();

    // R5 / R8: passive toggle silent; levels appear one cycle late
    si = 0; ei = 1;
    cyc(0,0,0,0, 1,0,0, 0,0,8'h00);
    chk("R5 passive tracked", {31'b0, rdata[5]}, 32'h1);
    chk("R8 passive no irq", {31'b0, irq}, 32'h0);
    cyc(0,0,0,0, 0,0,0, 0,0,8'h00);
    chk("R8 passive fall no irq", {31'b0, irq}, 32'h0);

    // R6: warn and bus-off rises with/without enable
    cyc(0,0,0,0, 0,1,0, 0,0,8'h00);
    chk("R6 warn rise irq", {31'b0, irq}, 32'h1);
    rdclr();
    idle();
    chk("R6 held level no re-raise", {31'b0, irq}, 32'h0);
    cyc(0,0,0,0, 0,1,1, 0,0,8'h00);
    chk("R6 bus-off rise irq", {31'b0, irq}, 32'h1);
    chk("R5 levels in bits 7:6", {24'b0, rdata[7:5], 5'b0}, 32'hC0);
    rdclr();
    ei = 0;
    cyc(0,0,0,0, 0,0,0, 0,0,8'h00);
    cyc(0,0,0,0, 0,1,1, 0,0,8'h00);
    chk("R8 rise masked", {31'b0, irq}, 32'h0);
    cyc(0,0,0,0, 0,0,0, 0,0,8'h00);

    // R10: read with concurrent source keeps pending
    si = 1;
    cyc(1,0,0,0, 0,0,0, 0,0,8'h00);
    cyc(0,1,0,0, 0,0,0, 1,0,8'h00);
    chk("R10 read plus source stays pending", {31'b0, irq}, 32'h1);
    rdclr();

    // R11: engine vs CPU on same field
    cyc(1,1,0,0, 0,0,0, 0,1,8'h07);
    chk("R11 engine beats write", rdata, 32'h18);
    rdclr();

    // R12: global gate and hold
    cyc(1,0,0,0, 0,0,0, 0,0,8'h00);
    gi = 0; #1;
    chk("R12 gated off", {31'b0, irq}, 32'h0);
    gi = 1; #1;
    chk("R12 pending held", {31'b0, irq}, 32'h1);
    rdclr();

    // model sweep, pseudo-random
    lf = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      ei = lf[0]; si = lf[1];
      cyc(lf[2] & lf[9], lf[3] & lf[10], lf[4] & lf[11], lf[7:5] % 3'd7,
          lf[8], lf[12] & lf[13], lf[14] & lf[15] & lf[3],
          lf[9] & lf[2], lf[11] & lf[6], lf[15:8]);
      chk("R1 R3 R6 R7 R10 R11 sweep status", rdata, {24'h0, m_stat});
      chk("R6 R7 R10 R12 sweep irq", {31'b0, irq}, {31'b0, m_pend & gi});
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule